// File: doc/BRIEF.md
# Card Detect Status-Change Controller

This block handles the card-detect control and status byte of a removable-card socket, together with the event logic behind it. It brings two voltage-sense pins and two active-low card-detect pins into the clock domain. It flags a change each time the card goes from present to absent or from absent to present. From that change, or from a software request, it raises a card-detect status-change interrupt. When resume is enabled, a detect change pulls an active-low wake line low, and the line stays low until software acknowledges the change. If software has asked for it, taking the card out sends a one-cycle request to reset the socket's compatibility registers.

Software reaches the block over a small register bus with an address, a read enable, a write strobe and byte data. Four addresses are decoded. One is the control byte. The other three are local stand-ins for the interrupt-enable register, the status-change register and the global-control bit that the control byte works with. The retained bits have two reset inputs. Which of them clears the bits depends on whether power-management events are enabled.

Top module: `cdsc_top`

## Requirements
- R1: Reading the control byte (address 0) returns the VS2 sense pin level in bit 7 and the VS1 level in bit 6, where 1 means high. These bits have no stored value and follow the pins through a two-flop synchroniser. A pin change made before clock edge k can be read after edge k+2.
- R2: Bit 5 of the control byte is a software detect trigger, and it always reads 0. A write with bit 5 set is accepted only while the detect-enable bit (bit 3 at address 1) is 1, and an accepted write sets status bit 3 at the second clock edge after the write. If the enable bit is 0, the write has no effect.
- R3: While global bit 2 (address 3) is 1, a write-1 to status bit 3 (address 2) made the cycle after an accepted software trigger cancels the pending request, so status bit 3 stays 0. While global bit 2 is 0, the same sequence still sets status bit 3.
- R4: When control bit 4 (resume enable) is 1, a detect change drives the wake output low three clock edges after the pin change. The output stays low until a write-1 to status bit 3, and returns high at that write's clock edge. A software trigger never drives the wake output low.
- R5: Bits 3, 2 and 0 of the control byte read 0, and writes to them are ignored.
- R6: When control bit 1 is 1, a present-to-absent change produces a reset-request pulse exactly one cycle long, three edges after the pin change. No pulse is produced on insertion or when bit 1 is 0.
- R7: While power-management events are enabled, only the global reset clears the retained bits. While they are disabled, either the bus reset or the global reset clears them, and every retained bit resets to 0.
- R8: A card counts as present only when both detect pins are low. A change in presence sets status bit 3 three edges after the pin change. The interrupt output is high while status bit 3 and the enable bit are both 1.
- R9: The register map is address 0 for control, 1 for the enable (bit 3), 2 for status (bit 3, write-1-to-clear) and 3 for global control (bit 2). Unimplemented bits read 0, and read data is 0 while the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| gRstN | input | 1 | Global reset, active low, asynchronous |
| pciRstN | input | 1 | Bus reset, active low; ignored while pmeEn is 1 |
| pmeEn | input | 1 | Power-management events enabled |
| cdPinN | input | 2 | Card-detect pins, active low |
| vsPin | input | 2 | Voltage-sense pins: [1] is VS2, [0] is VS1 |
| busAddr | input | ADDR_W | Register address |
| busRd | input | 1 | Read enable |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| cscIrq | output | 1 | Card-detect status-change interrupt |
| ringN | output | 1 | Wake output, active low |
| sockRegRst | output | 1 | One-cycle request to reset the socket registers |

## Verification
The bench sends a software trigger and then, on the very next cycle, writes the status clear. It does this once with the global bit set and once with it clear. A design that ignored the global bit, or that let the clear beat the pending set, would raise the interrupt in the wrong one of the two runs. The bench also drives a single detect pin low, which an OR-based presence check would wrongly take as an insertion. It removes the card with the removal bit both set and clear, to catch a reset-request pulse that is missing, lasts more than one cycle, or fires on insertion. Finally it pulses the bus reset with power-management events on and then off, which exposes retained bits that are tied to the wrong reset.

// File: rtl/cdsc_pkg.sv
package cdsc_pkg;
  localparam int DATA_W = 8;

  // control byte fields
  localparam int CTL_VS2 = 7;
  localparam int CTL_VS1 = 6;
  localparam int CTL_SWT = 5;
  localparam int CTL_RES = 4;
  localparam int CTL_RMV = 1;

  // companion register fields
  localparam int CFG_CDEN  = 3;
  localparam int STAT_CD   = 3;
  localparam int GLB_SWCLR = 2;

  typedef struct packed {
    logic ctlWr;
    logic cfgWr;
    logic glbWr;
    logic swTrig;
    logic cdClr;
    logic swCancel;
    logic resumeVal;
    logic removalVal;
    logic cdEnVal;
    logic glbVal;
  } strobe_t;
endpackage

// File: rtl/cdsc_sync.sv
module cdsc_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= {WIDTH{RST_VAL}};
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= {WIDTH{RST_VAL}};
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cdsc_ctrl.sv
module cdsc_ctrl
  import cdsc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 0,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2,
  parameter logic [ADDR_W-1:0] GLB_ADDR  = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cdEn,
  input  logic              glbSwClr,
  output strobe_t           stb
);
  logic unusedBits;
  assign unusedBits = ^{busWdata[7:6], busWdata[0]};

  always_comb begin
    stb            = '0;
    stb.ctlWr      = busWr && (busAddr == CTL_ADDR);
    stb.cfgWr      = busWr && (busAddr == CFG_ADDR);
    stb.glbWr      = busWr && (busAddr == GLB_ADDR);
    stb.swTrig     = stb.ctlWr && busWdata[CTL_SWT] && cdEn;
    stb.cdClr      = busWr && (busAddr == STAT_ADDR) && busWdata[STAT_CD];
    stb.swCancel   = stb.cdClr && glbSwClr;
    stb.resumeVal  = busWdata[CTL_RES];
    stb.removalVal = busWdata[CTL_RMV];
    stb.cdEnVal    = busWdata[CFG_CDEN];
    stb.glbVal     = busWdata[GLB_SWCLR];
  end
endmodule

// File: rtl/cdsc_dp.sv
module cdsc_dp
  import cdsc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 0,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2,
  parameter logic [ADDR_W-1:0] GLB_ADDR  = 3
) (
  input  logic              clk,
  input  logic              gRstN,
  input  logic              retRstN,
  input  strobe_t           stb,
  input  logic              present,
  input  logic [1:0]        vsSync,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              cdEn,
  output logic              glbSwClr,
  output logic              resumeEn,
  output logic              removalEn,
  output logic              cdChange,
  output logic              cscIrq,
  output logic              ringN,
  output logic              sockRegRst
);
  logic presPrev, hwChange, swReq, wakeHold;

  always_ff @(posedge clk or negedge gRstN) begin
    if (!gRstN) presPrev <= 1'b0;
    else        presPrev <= present;
  end

  assign hwChange = present ^ presPrev;

  always_ff @(posedge clk or negedge retRstN) begin
    if (!retRstN) begin
      resumeEn   <= 1'b0;
      removalEn  <= 1'b0;
      cdEn       <= 1'b0;
      glbSwClr   <= 1'b0;
      swReq      <= 1'b0;
      cdChange   <= 1'b0;
      wakeHold   <= 1'b0;
      sockRegRst <= 1'b0;
    end else begin
      if (stb.ctlWr) begin
        resumeEn  <= stb.resumeVal;
        removalEn <= stb.removalVal;
      end
      if (stb.cfgWr) cdEn     <= stb.cdEnVal;
      if (stb.glbWr) glbSwClr <= stb.glbVal;
      // software request lives one cycle, unless cancelled
      swReq <= stb.swTrig;
      if (hwChange || (swReq && !stb.swCancel)) cdChange <= 1'b1;
      else if (stb.cdClr)                       cdChange <= 1'b0;
      if (hwChange && resumeEn) wakeHold <= 1'b1;
      else if (stb.cdClr)       wakeHold <= 1'b0;
      sockRegRst <= removalEn && presPrev && !present;
    end
  end

  assign cscIrq = cdChange && cdEn;
  assign ringN  = !wakeHold;

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        CTL_ADDR: begin
          busRdata[CTL_VS2] = vsSync[1];
          busRdata[CTL_VS1] = vsSync[0];
          busRdata[CTL_RES] = resumeEn;
          busRdata[CTL_RMV] = removalEn;
        end
        CFG_ADDR:  busRdata[CFG_CDEN]  = cdEn;
        STAT_ADDR: busRdata[STAT_CD]   = cdChange;
        GLB_ADDR:  busRdata[GLB_SWCLR] = glbSwClr;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cdsc_top.sv
module cdsc_top
  import cdsc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 0,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2,
  parameter logic [ADDR_W-1:0] GLB_ADDR  = 3
) (
  input  logic              clk,
  input  logic              gRstN,
  input  logic              pciRstN,
  input  logic              pmeEn,
  input  logic [1:0]        cdPinN,
  input  logic [1:0]        vsPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              cscIrq,
  output logic              ringN,
  output logic              sockRegRst
);
  logic effRstN, present, cdEn, glbSwClr, resumeEn, removalEn, cdChange;
  logic [1:0] cdSync, vsSync;
  strobe_t stb;

  assign effRstN = gRstN && (pciRstN || pmeEn);

  cdsc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cdSync (
    .clk(clk), .rstN(gRstN), .din(cdPinN), .dout(cdSync));

  cdsc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vsSync (
    .clk(clk), .rstN(gRstN), .din(vsPin), .dout(vsSync));

  assign present = !cdSync[0] && !cdSync[1];

  cdsc_ctrl #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .CFG_ADDR(CFG_ADDR),
              .STAT_ADDR(STAT_ADDR), .GLB_ADDR(GLB_ADDR)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .cdEn(cdEn), .glbSwClr(glbSwClr), .stb(stb));

  cdsc_dp #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .CFG_ADDR(CFG_ADDR),
            .STAT_ADDR(STAT_ADDR), .GLB_ADDR(GLB_ADDR)) u_dp (
    .clk(clk), .gRstN(gRstN), .retRstN(effRstN), .stb(stb),
    .present(present), .vsSync(vsSync), .busAddr(busAddr), .busRd(busRd),
    .busRdata(busRdata), .cdEn(cdEn), .glbSwClr(glbSwClr),
    .resumeEn(resumeEn), .removalEn(removalEn), .cdChange(cdChange),
    .cscIrq(cscIrq), .ringN(ringN), .sockRegRst(sockRegRst));
endmodule

// File: rtl/cdsc_chk.sv
module cdsc_chk #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [7:0]        busRdata,
  input logic              ringN,
  input logic              sockRegRst,
  input logic              resumeEn,
  input logic              removalEn
);
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == CTL_ADDR) |-> (busRdata[3:2] == 2'b00 && !busRdata[0]));

  // R2
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == CTL_ADDR) |-> !busRdata[5]);

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 8'h00);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sockRegRst |=> !sockRegRst);

  // R6
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sockRegRst |-> $past(removalEn));

  // R4
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ringN) |-> $past(resumeEn));
endmodule

bind cdsc_top cdsc_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rstN(effRstN), .busAddr(busAddr), .busRd(busRd),
  .busRdata(busRdata), .ringN(ringN), .sockRegRst(sockRegRst),
  .resumeEn(resumeEn), .removalEn(removalEn));

// File: tb/sim_cdsc_top.sv
module sim_cdsc_top;
  localparam logic [1:0] A_CTL = 2'd0, A_CFG = 2'd1, A_STAT = 2'd2, A_GLB = 2'd3;
  localparam int S_RD = 0, S_IRQ = 1, S_RING = 2, S_SOCK = 3;

  logic clk = 1'b0;
  logic gRstN = 1'b0, pciRstN = 1'b0, pmeEn = 1'b0;
  logic [1:0] cdPinN = 2'b11, vsPin = 2'b00, busAddr = 2'd0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00, busRdata;
  logic cscIrq, ringN, sockRegRst;

  always #5 clk = ~clk;

  cdsc_top u0 (
    .clk(clk), .gRstN(gRstN), .pciRstN(pciRstN), .pmeEn(pmeEn),
    .cdPinN(cdPinN), .vsPin(vsPin), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .cscIrq(cscIrq), .ringN(ringN), .sockRegRst(sockRegRst));

  typedef struct {
    int cyc;
    int sel;
    logic [7:0] val;
    string req;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void expectAt(int dly, int sel, logic [7:0] v, string req);
    item_t it;
    it.cyc = cyc + dly;
    it.sel = sel;
    it.val = v;
    it.req = req;
    sbq.push_back(it);
  endfunction

  function automatic logic [7:0] pick(int sel);
    case (sel)
      S_RD:    return busRdata;
      S_IRQ:   return {7'b0, cscIrq};
      S_RING:  return {7'b0, ringN};
      default: return {7'b0, sockRegRst};
    endcase
  endfunction

  // monitor: pops expected items when their cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        item_t it;
        logic [7:0] obs;
        it = sbq.pop_front();
        obs = pick(it.sel);
        checks++;
        if (obs !== it.val) begin
          errors++;
          $display("FAIL %s sel=%0d cyc=%0d got %h exp %h", it.req, it.sel, cyc, obs, it.val);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string req);
    busAddr = a; busRd = 1'b1;
    expectAt(0, S_RD, e, req);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin
    idle(3);
    gRstN = 1'b1; pciRstN = 1'b1;
    idle(1);
    // reset state (R7)
    rd(A_CTL, 8'h00, "R7 reset ctl");
    expectAt(0, S_IRQ, 0, "R7 reset irq");
    expectAt(0, S_RING, 1, "R7 reset ring");
    expectAt(0, S_SOCK, 0, "R7 reset sock");
    idle(1);

    // R1 sense pins
    vsPin = 2'b10; idle(2);
    rd(A_CTL, 8'h80, "R1 vs2");
    vsPin = 2'b01; idle(2);
    rd(A_CTL, 8'h40, "R1 vs1");
    vsPin = 2'b00; idle(2);

    // R5 reserved bits ignore writes
    wr(A_CTL, 8'hFF);
    rd(A_CTL, 8'h12, "R5 reserved");
    wr(A_CTL, 8'h00);
    rd(A_CTL, 8'h00, "R5 cleared");

    // R2 trigger with enable off
    wr(A_CTL, 8'h20);
    idle(3);
    expectAt(0, S_IRQ, 0, "R2 disabled irq");
    rd(A_STAT, 8'h00, "R2 disabled status");

    // R2 trigger with enable on
    wr(A_CFG, 8'h08);
    rd(A_CFG, 8'h08, "R9 cfg");
    wr(A_CTL, 8'h20);
    expectAt(0, S_IRQ, 0, "R2 not yet");
    expectAt(1, S_IRQ, 1, "R2 irq");
    expectAt(1, S_RING, 1, "R4 sw no wake");
    idle(2);
    rd(A_CTL, 8'h00, "R2 reads zero");
    rd(A_STAT, 8'h08, "R2 status");
    wr(A_STAT, 8'h08);
    expectAt(0, S_IRQ, 0, "R8 w1c irq");
    rd(A_STAT, 8'h00, "R8 w1c status");

    // R3 cancel with global bit set
    wr(A_GLB, 8'h04);
    rd(A_GLB, 8'h04, "R9 glb");
    wr(A_CTL, 8'h20);
    wr(A_STAT, 8'h08);
    expectAt(0, S_IRQ, 0, "R3 cancelled");
    expectAt(1, S_IRQ, 0, "R3 cancelled later");
    idle(2);
    rd(A_STAT, 8'h00, "R3 status");
    // R3 same sequence with global bit clear
    wr(A_GLB, 8'h00);
    wr(A_CTL, 8'h20);
    wr(A_STAT, 8'h08);
    expectAt(0, S_IRQ, 1, "R3 not cancelled");
    idle(1);
    rd(A_STAT, 8'h08, "R3 status set");
    wr(A_STAT, 8'h08);

    // R4 insertion with resume
    wr(A_CTL, 8'h10);
    cdPinN = 2'b00;
    expectAt(2, S_RING, 1, "R4 ring early");
    expectAt(3, S_IRQ, 1, "R8 insert irq");
    expectAt(3, S_RING, 0, "R4 ring low");
    expectAt(3, S_SOCK, 0, "R6 no pulse on insert");
    idle(8);
    expectAt(0, S_RING, 0, "R4 ring held");
    wr(A_STAT, 8'h08);
    expectAt(0, S_RING, 1, "R4 ring release");
    expectAt(0, S_IRQ, 0, "R8 irq clear");
    idle(1);

    // R6 removal with bit 1
    wr(A_CTL, 8'h02);
    cdPinN = 2'b11;
    expectAt(2, S_SOCK, 0, "R6 early");
    expectAt(3, S_SOCK, 1, "R6 pulse");
    expectAt(3, S_RING, 1, "R4 resume off");
    expectAt(4, S_SOCK, 0, "R6 one cycle");
    idle(6);
    wr(A_STAT, 8'h08);

    // R8 one pin low is not present
    cdPinN = 2'b10;
    idle(5);
    expectAt(0, S_IRQ, 0, "R8 single pin");
    rd(A_STAT, 8'h00, "R8 single pin status");
    cdPinN = 2'b11;
    idle(4);

    // R6 removal with bit 1 clear
    wr(A_CTL, 8'h00);
    cdPinN = 2'b00;
    idle(5);
    wr(A_STAT, 8'h08);
    cdPinN = 2'b11;
    expectAt(3, S_SOCK, 0, "R6 disabled");
    expectAt(4, S_SOCK, 0, "R6 disabled later");
    idle(6);
    wr(A_STAT, 8'h08);

    // R7 reset sources
    pmeEn = 1'b1;
    wr(A_CTL, 8'h12);
    pciRstN = 1'b0; idle(2); pciRstN = 1'b1; idle(1);
    rd(A_CTL, 8'h12, "R7 pme keeps");
    rd(A_CFG, 8'h08, "R7 pme keeps cfg");
    pmeEn = 1'b0;
    pciRstN = 1'b0; idle(2); pciRstN = 1'b1; idle(1);
    rd(A_CTL, 8'h00, "R7 bus reset clears");
    rd(A_CFG, 8'h00, "R7 bus reset clears cfg");
    pmeEn = 1'b1;
    wr(A_CTL, 8'h12);
    gRstN = 1'b0; idle(2); gRstN = 1'b1; idle(3);
    rd(A_CTL, 8'h00, "R7 global clears");

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule